// File: doc/BRIEF.md
# System-Call Trap State Unit

This unit computes the architectural state changes that a system-call instruction causes in a 64-bit core. It samples a request on a rising clock edge. A request carries the current instruction address, the 32-bit instruction word, the live machine-state word and a micro-op code. The results are registered and show up on the outputs on that same edge.

When the sampled request is a system call, the unit produces four values, each with its own write-enable:

- the return address for the first save/restore register;
- a masked copy of the machine-state word for the second save/restore register;
- a new machine-state word, with translation, interrupt-enable, recoverability and floating-point exception mode bits cleared and the hypervisor bit set from the instruction;
- the fixed handler address `0xC00`.

Any other micro-op, and any cycle with no request, leaves every write-enable low and every data output at zero.

In the text below, "bit n" means the LSB-numbered index. Big-endian bit k of a 64-bit word is bit 63-k. Big-endian bit k of the 32-bit instruction is bit 31-k.

A small controller tracks which result the output registers hold. It has three states:

- `ST_IDLE`: nothing was sampled.
- `ST_SYSCALL`: a system-call result is held.
- `ST_OTHER`: a non-system-call op was sampled.

Transitions are evaluated on every edge from any state:

- `GO_SYSCALL` is taken on a valid request whose op equals the system-call code (default 7'd17).
- `GO_OTHER` is taken on a valid request with any other op.
- `GO_IDLE` is taken when no request is valid.

Top module: `scu_trap_unit`

## Requirements
- R1: While reset is high, and after it until the first valid request, every write-enable output is low and every data output is zero.
- R2: A request sampled with `in_valid` high on a rising edge is reflected on all outputs right after that edge and held until the next edge. The four write-enables are high together exactly when the sampled op equals the system-call code.
- R3: On a system call, `srr0_data` equals the sampled instruction address plus 4, modulo 2^64.
- R4: On a system call, bits 16 to 21 and bits 27 to 30 of `srr1_data` are zero.
- R5: On a system call, all other bits of `srr1_data` (0 to 15, 22 to 26, 31 to 63) equal the sampled machine-state word.
- R6: On a system call, every bit of `msr_data` other than bits 1, 4, 5, 8, 11, 15 and 60 equals the sampled machine-state word, including bits 16 to 21 and 27 to 30.
- R7: On a system call, `msr_data` bits 15 (external interrupt enable), 11 and 8 (floating-point exception modes), 5 (instruction relocation), 4 (data relocation) and 1 (recoverable interrupt) are zero.
- R8: On a system call, `msr_data` bit 60 (hypervisor) is 1 when instruction bits 11 down to 5 (big-endian 20 to 26) equal 1, and 0 for any other value.
- R9: On a system call, `nia_data` equals 0xC00.
- R10: After a non-system-call op, or a cycle without a valid request, all write-enables are low and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 7 | Micro-op code |
| in_cia | input | 64 | Current instruction address |
| in_insn | input | 32 | Instruction word |
| in_msr | input | 64 | Current machine-state word |
| srr0_data | output | 64 | Return address to save |
| srr0_ok | output | 1 | Write-enable for `srr0_data` |
| srr1_data | output | 64 | Status word to save |
| srr1_ok | output | 1 | Write-enable for `srr1_data` |
| msr_data | output | 64 | New machine-state word |
| msr_ok | output | 1 | Write-enable for `msr_data` |
| nia_data | output | 64 | Next instruction address (handler vector) |
| nia_ok | output | 1 | Write-enable for `nia_data` |

## Verification
Two functions can land in the same result.

- **Return-address wrap together with hypervisor override.** The carry out of the return-address adder is lost on wrap, and in the same cycle the hypervisor override rewrites a bit inside the copied high range of the new machine-state word. A directed request provokes this with address `FFFF_FFFF_FFFF_FFFC`, an all-ones state word and a level field of 1. The outputs must read zero, the masked status copy, and a state word with only the six cleared bits low.
- **Masked copy together with cleared enables.** The status-word masking and the enable clearing act on the same incoming word. Random state words with random level fields exercise both at once.

Every output is compared with reference functions written from the requirements, one cycle after the request is sampled.

// File: rtl/scu_pkg.sv
package scu_pkg;

    localparam int XLEN = 64;
    localparam int ILEN = 32;
    localparam int OP_W = 7;

    localparam logic [OP_W-1:0] OP_SYSCALL = 7'd17;
    localparam logic [XLEN-1:0] SC_VECTOR  = 64'h0000_0000_0000_0C00;
    localparam logic [XLEN-1:0] PC_STEP    = 64'd4;

    // big-endian index -> LSB index helpers
    function automatic int be_to_le(input int be, input int width);
        return width - 1 - be;
    endfunction

    // Machine-state bit positions (LSB numbering)
    localparam int BIT_HV  = XLEN - 1 - 3;
    localparam int BIT_EE  = XLEN - 1 - 48;
    localparam int BIT_FE0 = XLEN - 1 - 52;
    localparam int BIT_FE1 = XLEN - 1 - 55;
    localparam int BIT_IR  = XLEN - 1 - 58;
    localparam int BIT_DR  = XLEN - 1 - 59;
    localparam int BIT_RI  = XLEN - 1 - 62;

    // level field: big-endian instruction bits 20..26
    localparam int LEV_HI = ILEN - 1 - 20;
    localparam int LEV_LO = ILEN - 1 - 26;
    localparam int LEV_W  = LEV_HI - LEV_LO + 1;
    localparam logic [LEV_W-1:0] LEV_HYP = LEV_W'(1);

    // Bits of the saved status word that keep the incoming value
    function automatic logic [XLEN-1:0] srr1_keep_mask();
        logic [XLEN-1:0] m;
        m = '1;
        for (int be = 0; be < XLEN; be++) begin
            if ((be >= 33 && be <= 36) || (be >= 42 && be <= 47))
                m[be_to_le(be, XLEN)] = 1'b0;
        end
        return m;
    endfunction

    // Bits of the new machine-state word forced low
    function automatic logic [XLEN-1:0] msr_clear_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[BIT_EE]  = 1'b1;
        m[BIT_FE0] = 1'b1;
        m[BIT_FE1] = 1'b1;
        m[BIT_IR]  = 1'b1;
        m[BIT_DR]  = 1'b1;
        m[BIT_RI]  = 1'b1;
        return m;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SYSCALL = 2'd1,
        ST_OTHER   = 2'd2
    } scu_state_e;

    typedef struct packed {
        logic [XLEN-1:0] srr0;
        logic [XLEN-1:0] srr1;
        logic [XLEN-1:0] msr;
        logic [XLEN-1:0] nia;
    } scu_result_t;

endpackage

// File: rtl/scu_save_builder.sv
module scu_save_builder
    import scu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] cia,
    input  logic [W-1:0] msr_in,
    output logic [W-1:0] srr0,
    output logic [W-1:0] srr1
);
    localparam logic [XLEN-1:0] KEEP = srr1_keep_mask();

    always_comb begin
        srr0 = cia + W'(PC_STEP);
        srr1 = msr_in & W'(KEEP);
    end
endmodule

// File: rtl/scu_state_builder.sv
module scu_state_builder
    import scu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]     msr_in,
    input  logic [LEV_W-1:0] level,
    output logic [W-1:0]     msr_new
);
    localparam logic [XLEN-1:0] CLR = msr_clear_mask();

    always_comb begin
        msr_new         = msr_in & ~W'(CLR);
        msr_new[BIT_HV] = (level == LEV_HYP);
    end
endmodule

// File: rtl/scu_ctrl_fsm.sv
module scu_ctrl_fsm
    import scu_pkg::*;
#(
    parameter int               OPW     = OP_W,
    parameter logic [OPW-1:0]   SC_CODE = OP_SYSCALL
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [OPW-1:0] in_op,
    output scu_state_e state,
    output scu_state_e state_nxt
);
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_SYSCALL, ST_OTHER: begin
                if (!in_valid)             state_nxt = ST_IDLE;     // GO_IDLE
                else if (in_op == SC_CODE) state_nxt = ST_SYSCALL;  // GO_SYSCALL
                else                       state_nxt = ST_OTHER;    // GO_OTHER
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end
endmodule

// File: rtl/scu_trap_unit.sv
module scu_trap_unit
    import scu_pkg::*;
#(
    parameter int                W       = XLEN,
    parameter int                IW      = ILEN,
    parameter int                OPW     = OP_W,
    parameter logic [OPW-1:0]    SC_CODE = OP_SYSCALL
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [OPW-1:0] in_op,
    input  logic [W-1:0]   in_cia,
    input  logic [IW-1:0]  in_insn,
    input  logic [W-1:0]   in_msr,
    output logic [W-1:0]   srr0_data,
    output logic           srr0_ok,
    output logic [W-1:0]   srr1_data,
    output logic           srr1_ok,
    output logic [W-1:0]   msr_data,
    output logic           msr_ok,
    output logic [W-1:0]   nia_data,
    output logic           nia_ok
);
    scu_state_e      state, state_nxt;
    logic [W-1:0]    srr0_c, srr1_c, msr_c;
    logic [LEV_W-1:0] level;
    scu_result_t     res_q;
    logic            write_en;

    logic unused_insn;
    assign unused_insn = ^{in_insn[IW-1:LEV_HI+1], in_insn[LEV_LO-1:0]};
    assign level = in_insn[LEV_HI:LEV_LO];

    scu_ctrl_fsm #(.OPW(OPW), .SC_CODE(SC_CODE)) u_fsm (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .state(state), .state_nxt(state_nxt)
    );

    scu_save_builder #(.W(W)) u_save (
        .cia(in_cia), .msr_in(in_msr), .srr0(srr0_c), .srr1(srr1_c)
    );

    scu_state_builder #(.W(W)) u_state (
        .msr_in(in_msr), .level(level), .msr_new(msr_c)
    );

    // output register process
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (state_nxt == ST_SYSCALL) begin
            res_q.srr0 <= srr0_c;
            res_q.srr1 <= srr1_c;
            res_q.msr  <= msr_c;
            res_q.nia  <= W'(SC_VECTOR);
        end else begin
            res_q <= '0;
        end
    end

    always_comb begin
        write_en = 1'b0;
        unique case (state)
            ST_SYSCALL:        write_en = 1'b1;
            ST_IDLE, ST_OTHER: write_en = 1'b0;
            default:           write_en = 1'b0;
        endcase
    end

    assign srr0_data = res_q.srr0;
    assign srr1_data = res_q.srr1;
    assign msr_data  = res_q.msr;
    assign nia_data  = res_q.nia;
    assign srr0_ok   = write_en;
    assign srr1_ok   = write_en;
    assign msr_ok    = write_en;
    assign nia_ok    = write_en;
endmodule

// File: rtl/scu_trap_chk.sv
module scu_trap_chk
    import scu_pkg::*;
#(
    parameter int             W       = XLEN,
    parameter int             IW      = ILEN,
    parameter int             OPW     = OP_W,
    parameter logic [OPW-1:0] SC_CODE = OP_SYSCALL
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [OPW-1:0] in_op,
    input logic [W-1:0]   in_cia,
    input logic [IW-1:0]  in_insn,
    input logic [W-1:0]   in_msr,
    input logic [W-1:0]   srr0_data,
    input logic           srr0_ok,
    input logic [W-1:0]   srr1_data,
    input logic           srr1_ok,
    input logic [W-1:0]   msr_data,
    input logic           msr_ok,
    input logic [W-1:0]   nia_data,
    input logic           nia_ok
);
    localparam logic [W-1:0] KEEP = W'(srr1_keep_mask());
    localparam logic [W-1:0] CLR  = W'(msr_clear_mask());
    localparam logic [W-1:0] MSR_FREE = ~(CLR | (W'(1) << BIT_HV));

    logic live;
    always_ff @(posedge clk) live <= !rst;

    logic sc_req;
    assign sc_req = in_valid && (in_op == SC_CODE);

    AST_OKS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        (srr0_ok == srr1_ok) && (srr1_ok == msr_ok) && (msr_ok == nia_ok)); // R2
    AST_OK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        live |-> (srr0_ok == $past(sc_req))); // R2
    AST_SRR0_STEP: assert property (@(posedge clk) disable iff (rst)
        (live && $past(sc_req)) |-> (srr0_data == $past(in_cia) + W'(4))); // R3
    AST_SRR1_HOLES: assert property (@(posedge clk) disable iff (rst)
        srr1_ok |-> ((srr1_data & ~KEEP) == '0)); // R4
    AST_SRR1_COPY: assert property (@(posedge clk) disable iff (rst)
        (live && $past(sc_req)) |-> ((srr1_data & KEEP) == ($past(in_msr) & KEEP))); // R5
    AST_MSR_COPY: assert property (@(posedge clk) disable iff (rst)
        (live && $past(sc_req)) |-> ((msr_data & MSR_FREE) == ($past(in_msr) & MSR_FREE))); // R6
    AST_MSR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        msr_ok |-> ((msr_data & CLR) == '0)); // R7
    AST_HV_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (live && $past(sc_req)) |-> (msr_data[BIT_HV] == ($past(in_insn[LEV_HI:LEV_LO]) == LEV_HYP))); // R8
    AST_NIA_VECTOR: assert property (@(posedge clk) disable iff (rst)
        nia_ok |-> (nia_data == W'(SC_VECTOR))); // R9
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !srr0_ok |-> ((srr0_data | srr1_data | msr_data | nia_data) == '0)); // R10
endmodule

bind scu_trap_unit scu_trap_chk #(.W(W), .IW(IW), .OPW(OPW), .SC_CODE(SC_CODE)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_cia(in_cia),
    .in_insn(in_insn), .in_msr(in_msr), .srr0_data(srr0_data), .srr0_ok(srr0_ok),
    .srr1_data(srr1_data), .srr1_ok(srr1_ok), .msr_data(msr_data), .msr_ok(msr_ok),
    .nia_data(nia_data), .nia_ok(nia_ok)
);

// File: tb/scu_trap_unit_tb.sv
module scu_trap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [6:0]  in_op;
    logic [63:0] in_cia;
    logic [31:0] in_insn;
    logic [63:0] in_msr;
    logic [63:0] srr0_data, srr1_data, msr_data, nia_data;
    logic        srr0_ok, srr1_ok, msr_ok, nia_ok;

    int n_checks = 0;
    int n_fail   = 0;
    localparam logic [6:0] SC = 7'd17;

    always #5 clk = ~clk;

    scu_trap_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_cia(in_cia),
        .in_insn(in_insn), .in_msr(in_msr), .srr0_data(srr0_data), .srr0_ok(srr0_ok),
        .srr1_data(srr1_data), .srr1_ok(srr1_ok), .msr_data(msr_data), .msr_ok(msr_ok),
        .nia_data(nia_data), .nia_ok(nia_ok)
    );

    function automatic logic [63:0] ref_srr1(input logic [63:0] m);
        logic [63:0] r = m;
        for (int be = 0; be < 64; be++)
            if ((be >= 33 && be <= 36) || (be >= 42 && be <= 47)) r[63-be] = 1'b0;
        return r;
    endfunction

    function automatic logic [63:0] ref_msr(input logic [63:0] m, input logic [31:0] insn);
        logic [63:0] r = m;
        r[15] = 1'b0; r[11] = 1'b0; r[8] = 1'b0;
        r[5]  = 1'b0; r[4]  = 1'b0; r[1] = 1'b0;
        r[60] = (insn[11:5] == 7'd1);
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, checked at following negedge
    task automatic apply(input logic v, input logic [6:0] op, input logic [63:0] cia,
                         input logic [31:0] insn, input logic [63:0] msr);
        logic sc;
        in_valid = v; in_op = op; in_cia = cia; in_insn = insn; in_msr = msr;
        @(negedge clk);
        sc = v && (op == SC);
        check("R2 ok flags", {60'd0, srr0_ok, srr1_ok, msr_ok, nia_ok}, sc ? 64'hF : 64'h0);
        if (sc) begin
            check("R3 srr0", srr0_data, cia + 64'd4);
            check("R4/R5 srr1", srr1_data, ref_srr1(msr));
            check("R6/R7/R8 msr", msr_data, ref_msr(msr, insn));
            check("R9 nia", nia_data, 64'hC00);
        end else begin
            check("R10 quiet data", srr0_data | srr1_data | msr_data | nia_data, 64'h0);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; in_valid = 1'b1; in_op = SC; in_cia = '1; in_insn = 32'h20; in_msr = '1;
        repeat (3) @(negedge clk);
        check("R1 reset ok", {60'd0, srr0_ok, srr1_ok, msr_ok, nia_ok}, 64'h0);
        check("R1 reset data", srr0_data | srr1_data | msr_data | nia_data, 64'h0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {60'd0, srr0_ok} | srr1_data | msr_data, 64'h0);

        // directed corners
        apply(1'b1, SC, 64'hFFFF_FFFF_FFFF_FFFC, 32'h0000_0020, '1);        // R3 wrap + R8 HV set
        apply(1'b1, SC, 64'h0000_0000_0000_1000, 32'h0000_0000, '0);        // R8 level 0
        apply(1'b1, SC, 64'h0000_0000_0000_2000, 32'h0000_0040, '1);        // R8 level 2 -> clear
        apply(1'b1, SC, 64'h0000_0000_0000_3000, 32'h0000_0FE0, 64'h1000_0000_0000_0000); // R8 level 127
        apply(1'b1, 7'd18, 64'h4, 32'h20, '1);                              // R10 other op
        apply(1'b0, SC, 64'h8, 32'h20, '1);                                 // R10 no request
        apply(1'b1, SC, 64'h10, 32'h20, 64'h0000_0000_7FFF_0000);           // R4/R6 middle bits
        apply(1'b1, SC, 64'h14, 32'h20, 64'h0000_0000_0000_8932);           // R7 cleared bits

        for (int i = 0; i < 400; i++) begin
            logic [31:0] insn = $urandom;
            logic [2:0]  sel  = 3'($urandom_range(0, 7));
            if (sel < 3) insn[11:5] = 7'd1;
            apply(sel != 7, (sel < 6) ? SC : 7'($urandom), rnd64(), insn, rnd64());
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule